// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block sits on the controller side of an SDRAM data path and turns a single read request into a command sequence that returns an exact number of words. A request carries a bank, a starting column and a word count. The block puts a READ on the command bus. When the burst would otherwise run past the wanted word, it then places a burst-stop command in the one cycle that cuts the burst after that word. The stop command is either BURST TERMINATE or PRECHARGE. The block samples the returned words from the data bus and presents each one with a valid strobe.

CAS latency (1, 2 or 3) and the burst mode are chosen per request. The mode is either full page or a fixed length of 1, 2, 4 or 8. The auto-precharge choice is also made per request. The stop command is timed so that it leaves the block CAS latency minus one cycles before the edge at which the last wanted word is valid. Counted from the READ cycle, that is always the cycle whose index equals the word count.

Top module: `sdram_rd_trunc`

## Requirements
- R1: After reset `cmd` is NOP (3'b111), `busy` and `rd_valid` are low and `dqm` is high.
- R2: An accepted request puts READ (3'b101) on `cmd` in the next cycle, with `ba` equal to the requested bank, `addr[8:0]` equal to the column, and `addr[10]` equal to `auto_pre` in fixed mode and 0 in full-page mode. `busy` is high from that cycle.
- R3: For a request of N words that needs truncation, the stop command appears on `cmd` in cycle N after the READ cycle, whatever the CAS latency. That is CL−1 cycles before the edge at which the last wanted word is valid, so a one-word request at CL=1 stops in the cycle right after READ. Every other cycle of the read carries NOP.
- R4: The stop command is BURST TERMINATE (3'b110) in full-page mode and in fixed mode without auto precharge.
- R5: In fixed mode with auto precharge, the stop command is PRECHARGE (3'b010), with `ba` equal to the bank of the read and `addr[10]` low.
- R6: In fixed mode, if the count is at least the burst length (2 to the power of `bl_code`), no stop command is issued and exactly one full burst of words is delivered.
- R7: `rd_valid` is high for exactly the delivered word count. Word k is the `dq_in` value in cycle CL+k after READ and is presented in the following cycle. The data model behind the bench returns column n+k for word k.
- R8: `busy` stays high until the cycle in which the last word is presented and is low in that cycle. A request raised while `busy` is high is ignored.
- R9: A request with a word count of zero is ignored: no command is issued and `busy` stays low.
- R10: `dqm` is low whenever `busy` is high and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_bank | input | BANK_W | Bank of the read |
| req_col | input | COL_W | Starting column |
| req_count | input | CNT_W | Number of words wanted |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| full_page | input | 1 | 1 selects full-page bursts, 0 fixed length |
| bl_code | input | 2 | Fixed burst length is 2**bl_code |
| auto_pre | input | 1 | Read with auto precharge (fixed mode) |
| cmd | output | 3 | Command {RAS_n, CAS_n, WE_n} |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus, bit 10 is the precharge/all-banks bit |
| dqm | output | 1 | Data mask, low during a read |
| dq_in | input | DQ_W | Read data from the memory |
| rd_data | output | DQ_W | Captured word |
| rd_valid | output | 1 | Captured word is valid |
| busy | output | 1 | Read in progress, new requests blocked |

## Verification
The same four-word read is run at CAS latency 1, 2 and 3. A wrong latency offset shows up either as a misplaced stop command or as shifted data. A single word at latency 1 covers the back-to-back READ and stop case. Fixed bursts with and without auto precharge, plus a full-page read, separate BURST TERMINATE from PRECHARGE and check the bank and bit 10 carried with PRECHARGE. A count at or above the burst length, a zero count and a request held high across a busy read show that the block leaves the burst alone or ignores the request as required.

// File: rtl/sdram_rd_trunc.sv
module sdram_rd_trunc #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int DQ_W   = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [1:0]        cas_lat,
  input  logic              full_page,
  input  logic [1:0]        bl_code,
  input  logic              auto_pre,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dqm,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   rd_data,
  output logic              rd_valid,
  output logic              busy
);
  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_BT  = 3'b110;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam int AP_BIT = 10;
  localparam int CYC_W  = CNT_W + 3;

  logic             active;
  logic [1:0]       cl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             term_q, pre_q;
  logic [CYC_W-1:0] cyc, cyc_nx, cl_w, cnt_w, last_cyc;

  logic [CNT_W-1:0] bl_len;
  logic             long_fixed;
  logic             accept;

  assign bl_len     = CNT_W'(1) << bl_code;
  assign long_fixed = !full_page && (req_count >= bl_len);
  assign accept     = req_valid && !active && (req_count != '0);

  assign cyc_nx   = cyc + 1'b1;
  assign cl_w     = CYC_W'(cl_q);
  assign cnt_w    = CYC_W'(cnt_q);
  assign last_cyc = cl_w + cnt_w - 1'b1;

  assign busy = active;
  assign dqm  = !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cyc    <= '0;
      cl_q   <= 2'd1;
      cnt_q  <= '0;
      term_q <= 1'b0;
      pre_q  <= 1'b0;
      cmd    <= C_NOP;
      ba     <= '0;
      addr   <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cyc    <= '0;
      cl_q   <= (cas_lat == 2'd0) ? 2'd1 : cas_lat;
      cnt_q  <= long_fixed ? bl_len : req_count;
      term_q <= !long_fixed;
      pre_q  <= !full_page && auto_pre;
      cmd    <= C_RD;
      ba     <= req_bank;
      addr   <= '0;
      addr[COL_W-1:0] <= req_col;
      addr[AP_BIT]    <= !full_page && auto_pre;
    end else if (active) begin
      cyc  <= cyc_nx;
      addr <= '0;
      if (term_q && cyc_nx == cnt_w)
        cmd <= pre_q ? C_PRE : C_BT;
      else
        cmd <= C_NOP;
      if (cyc == last_cyc)
        active <= 1'b0;
    end else begin
      cmd  <= C_NOP;
      addr <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= active && (cyc >= cl_w) && (cyc <= last_cyc);
      rd_data  <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_rd_trunc_chk.sv
module sdram_rd_trunc_chk #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              dqm,
  input logic              rd_valid,
  input logic              busy
);
  a_r3_nop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cmd == 3'b111);
  a_r2_read_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'b101 |-> $rose(busy));
  a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> cmd != 3'b101);
  a_r5_pre_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'b010 |-> !addr[10]);
  a_r7_valid_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(busy));
  a_r10_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dqm);
endmodule

bind sdram_rd_trunc sdram_rd_trunc_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .dqm(dqm),
  .rd_valid(rd_valid), .busy(busy));

// File: tb/sdram_rd_trunc_test.sv
module sdram_rd_trunc_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [1:0]  req_bank = 0;
  logic [8:0]  req_col = 0;
  logic [9:0]  req_count = 0;
  logic [1:0]  cas_lat = 1;
  logic        full_page = 0;
  logic [1:0]  bl_code = 3;
  logic        auto_pre = 0;
  logic [2:0]  cmd;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic        dqm;
  logic [15:0] dq_in = 16'hdead;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        busy;

  int total = 0;
  int bad = 0;
  logic [15:0] expq[$];

  always #10 clk = ~clk;

  sdram_rd_trunc uut (.*);

  function automatic logic [15:0] pat(input logic [1:0] b, input logic [8:0] c);
    return {5'b10100, b, c};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // memory model: drives the data bus from the observed command stream
  int  mcyc = 0, mstop = 0, mlim = 0, mcl = 1;
  bit  mlive = 0;
  logic [1:0] mbank;
  logic [8:0] mcol;
  always @(negedge clk) begin
    if (cmd == 3'b101) begin
      mlive = 1; mcyc = 0; mstop = 1 << 30; mcol = addr[8:0]; mbank = ba;
      mcl = cas_lat; mlim = full_page ? (1 << 30) : (1 << bl_code);
    end else if (mlive) begin
      mcyc++;
      if (cmd == 3'b110 || cmd == 3'b010) mstop = mcyc + mcl - 1;
    end
    if (mlive && mcyc >= mcl && (mcyc - mcl) < mlim && mcyc <= mstop)
      dq_in = pat(mbank, 9'(mcol + 9'(mcyc - mcl)));
    else
      dq_in = 16'hdead;
  end

  // monitor: compares captured words against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) chk(0, "R7 unexpected word", rd_data, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R7 data", rd_data, e);
      end
    end
  end

  task automatic issue(input logic [1:0] b, input logic [8:0] c, input int n,
                       input int cl, input bit fp, input int blc, input bit ap,
                       input bit hold);
    int neff, bl;
    bit term;
    logic [2:0] tcmd;
    bl = 1 << blc;
    term = fp || (n < bl);
    neff = term ? n : bl;
    tcmd = (!fp && ap) ? 3'b010 : 3'b110;
    for (int k = 0; k < neff; k++) expq.push_back(pat(b, 9'(c + 9'(k))));
    req_bank = b; req_col = c; req_count = 10'(n); cas_lat = 2'(cl);
    full_page = fp; bl_code = 2'(blc); auto_pre = ap; req_valid = 1;
    @(negedge clk);
    if (hold) begin req_bank = ~b; req_col = ~c; end
    else req_valid = 0;
    chk(cmd == 3'b101, "R2 read cmd", cmd, 3'b101);
    chk(ba == b && addr[8:0] == c, "R2 bank/col", {ba, addr[8:0]}, {b, c});
    chk(addr[10] == (!fp && ap), "R2 auto-precharge bit", addr[10], !fp && ap);
    chk(busy == 1 && dqm == 0, "R10 busy/dqm at read", {busy, dqm}, 2'b10);
    for (int cy = 1; cy <= cl + neff; cy++) begin
      @(negedge clk);
      if (term && cy == n) begin
        chk(cmd == tcmd, (tcmd == 3'b010) ? "R5 precharge" : "R4 terminate", cmd, tcmd);
        if (tcmd == 3'b010)
          chk(ba == b && addr[10] == 0, "R5 precharge bank", {ba, addr[10]}, {b, 1'b0});
        else
          chk(1, "R3 stop cycle", 0, 0);
      end else
        chk(cmd == 3'b111, term ? "R3 nop" : "R6 no stop", cmd, 3'b111);
      if (cy < cl + neff) chk(busy == 1, "R8 busy held", busy, 1);
      else chk(busy == 0 && dqm == 1, "R8 busy drop", {busy, dqm}, 2'b01);
    end
    req_valid = 0;
    @(negedge clk);
    chk(expq.size() == 0, "R7 word count", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        total++; bad++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd == 3'b111 && !busy && !rd_valid && dqm, "R1 reset",
        {cmd, busy, rd_valid, dqm}, {3'b111, 3'b001});
    rst_n = 1;
    @(negedge clk);
    chk(cmd == 3'b111 && !busy && !rd_valid && dqm, "R1 after reset",
        {cmd, busy, rd_valid, dqm}, {3'b111, 3'b001});
    issue(2'd1, 9'd16, 4, 1, 0, 3, 0, 0);   // R3 R4 CL1
    issue(2'd2, 9'd40, 4, 2, 0, 3, 0, 0);   // R3 CL2
    issue(2'd3, 9'd80, 4, 3, 0, 3, 0, 0);   // R3 CL3
    issue(2'd0, 9'd7,  1, 1, 0, 3, 0, 0);   // R3 one word, CL1
    issue(2'd2, 9'd100, 3, 2, 0, 3, 1, 0);  // R5 precharge
    issue(2'd1, 9'd509, 5, 3, 1, 0, 1, 0);  // R4 full page, column wrap
    issue(2'd3, 9'd20, 6, 2, 0, 2, 0, 0);   // R6 count above length
    issue(2'd0, 9'd60, 4, 3, 0, 2, 1, 0);   // R6 count equal length
    issue(2'd1, 9'd33, 3, 2, 0, 3, 0, 1);   // R8 request held while busy
    req_count = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!busy && cmd == 3'b111, "R9 zero count ignored", {busy, cmd}, 4'b0111);
    repeat (4) @(negedge clk);
    chk(!busy && cmd == 3'b111 && !rd_valid, "R9 still idle", {busy, cmd}, 4'b0111);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule